// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions toward an Ethernet PHY. Software hands it one packed 32-bit command word. The word holds the start pattern, the opcode, the PHY address, the register address, the turnaround bits and the data. When the write is accepted, the block sends 32 preamble ones and then shifts the word out on MDIO, most significant bit first. MDIO is paced by a management clock (MDC) that is divided down from the system clock.

For a read, the block releases the MDIO line from the second turnaround bit onward, so that the PHY can drive it. It shifts in the sixteen data bits the PHY returns. When the frame ends, those bits replace the low half of the command register, and the upper half keeps the command as written.

An idle flag tells software when the next command may be written. A port enable gates the whole block. The MDIO pad is assembled outside the block from `mdio_o`, `mdio_oe` and `mdio_i`.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `port_idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is 0. Whenever the block is idle, `mdc` and `mdio_oe` stay 0.
- R2: A write (`cmd_wr`) accepted while the block is idle and `mgmt_en` is 1 stores `cmd_wdata` and clears `port_idle` from the next cycle. The frame lasts exactly 64 MDC periods, and then `port_idle` returns to 1.
- R3: The frame on `mdio_o` is 32 ones followed by the stored word, most significant bit first. The word fields are:
  - bits [31:30]: start, 01
  - bits [29:28]: opcode, 10 = read and 01 = write
  - bits [27:23]: PHY address
  - bits [22:18]: register address
  - bits [17:16]: turnaround, 10
  - bits [15:0]: data
- R4: One MDC period is 48 clock cycles when `div_sel` is 0 and 64 clock cycles when `div_sel` is 1. MDC is low in the first half of each period and high in the second half.
- R5: `mdio_o` and `mdio_oe` change only where MDC falls, or at the start or end of a frame. `mdio_i` is sampled in the cycle where MDC rises.
- R6: For a read (opcode 10), `mdio_oe` is 1 for frame bits 0 to 46 and 0 for bits 47 to 63. Bit 47 is the second turnaround bit. For a write, `mdio_oe` stays 1 for all 64 bits.
- R7: After a read, `cmd_rdata[15:0]` holds the 16 bits sampled during frame bits 48 to 63, first sample in bit 15, and `cmd_rdata[31:16]` is unchanged. After a write, the whole register is unchanged.
- R8: A write to the command register while a frame is in progress is ignored. The register and the frame on the wire are unaffected.
- R9: While `mgmt_en` is 0, writes are ignored and MDC stays low. Dropping `mgmt_en` during a frame abandons the frame: from the next cycle `port_idle` is 1 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 1 | MDC divider select: 0 gives 48, 1 gives 64 |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Packed command word |
| cmd_rdata | output | 32 | Command register contents, including read data after a read |
| port_idle | output | 1 | 1 when a new command may be written |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
Two functions can fall in the same cycle.

The first pair is the end of a read and the register update. The last MDC falling edge both ends the frame and loads the captured data into the register. The bench checks that the idle flag and the new low half appear together, and that the upper half is untouched.

The second pair is a software write and the shift engine. A write issued in the middle of a frame must not disturb the word that is being shifted out. The bench provokes this with a second write during a transfer, then compares both the bit stream captured on MDC rising edges and the final register value against the first command.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;

    localparam int CMD_W        = 32;
    localparam int DATA_W       = 16;
    localparam int PRE_BITS     = 32;
    localparam int FRAME_BITS   = PRE_BITS + CMD_W;
    localparam int IDX_W        = $clog2(FRAME_BITS);
    // second turnaround bit of the frame: line released from here on reads
    localparam int RELEASE_BIT  = PRE_BITS + DATA_W - 1;
    localparam int DATA_FIRST   = PRE_BITS + DATA_W;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]        start;
        logic [1:0]        op;
        logic [4:0]        phy_ad;
        logic [4:0]        reg_ad;
        logic [1:0]        ta;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } mdc_tick_t;

    function automatic logic is_read(mdio_cmd_t c);
        return c.op == OP_READ;
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider
    import mdio_ctl_pkg::*;
#(
    parameter int DIV_LO = 48,
    parameter int DIV_HI = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      sel,
    output logic      mdc,
    output mdc_tick_t tick
);
    localparam int MAXDIV = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW     = $clog2(MAXDIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [CW-1:0] half;

    always_comb begin
        limit     = sel ? CW'(DIV_HI) : CW'(DIV_LO);
        half      = limit >> 1;
        tick.rise = run && (cnt == half - CW'(1));
        tick.fall = run && (cnt == limit - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick.fall) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + CW'(1);
            if (tick.rise)
                mdc <= 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              launch,
    input  mdio_cmd_t         word,
    input  mdc_tick_t         tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rx_data
);
    logic [IDX_W-1:0] idx;
    logic             rd;
    logic             last_bit;
    logic             in_data;

    assign rd       = is_read(word);
    assign last_bit = idx == IDX_W'(FRAME_BITS - 1);
    assign in_data  = idx >= IDX_W'(DATA_FIRST);
    assign rd_done  = busy && en && rd && tick.fall && last_bit;

    always_comb begin
        if (!busy || idx < IDX_W'(PRE_BITS))
            mdio_o = 1'b1;
        else
            mdio_o = word[~idx[4:0]];
        mdio_oe = busy && !(rd && idx >= IDX_W'(RELEASE_BIT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            rx_data <= '0;
        end else if (!en) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (tick.rise && rd && in_data)
                rx_data <= {rx_data[DATA_W-2:0], mdio_i};
            if (tick.fall) begin
                if (last_bit) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_ctl_pkg::*;
#(
    parameter int DIV_LO = 48,
    parameter int DIV_HI = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mgmt_en,
    input  logic        div_sel,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        port_idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t         cmd_q;
    logic              busy;
    logic              launch;
    logic              rd_done;
    logic [DATA_W-1:0] rx_data;
    mdc_tick_t         tick;

    assign launch    = cmd_wr && mgmt_en && !busy;
    assign port_idle = !busy;
    assign cmd_rdata = cmd_q;

    always_ff @(posedge clk) begin
        if (rst)
            cmd_q <= '0;
        else if (launch)
            cmd_q <= mdio_cmd_t'(cmd_wdata);
        else if (rd_done)
            cmd_q.data <= rx_data;
    end

    mdc_divider #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) div_i (
        .clk  (clk),
        .rst  (rst),
        .run  (busy && mgmt_en),
        .sel  (div_sel),
        .mdc  (mdc),
        .tick (tick)
    );

    mdio_frame_engine eng_i (
        .clk     (clk),
        .rst     (rst),
        .en      (mgmt_en),
        .launch  (launch),
        .word    (cmd_q),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_done (rd_done),
        .rx_data (rx_data)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        mgmt_en,
    input logic        cmd_wr,
    input logic [31:0] cmd_rdata,
    input logic        port_idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        port_idle |-> (!mdc && !mdio_oe)); // R1

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (port_idle && cmd_wr && mgmt_en) |=> !port_idle); // R2

    AST_OUT_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!port_idle && cmd_rdata[29:28] != 2'b10) |-> mdio_oe); // R6

    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!port_idle && cmd_wr) |=> $stable(cmd_rdata[31:16])); // R8

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !mgmt_en |=> (port_idle && !mdc)); // R9

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .mgmt_en   (mgmt_en),
    .cmd_wr    (cmd_wr),
    .cmd_rdata (cmd_rdata),
    .port_idle (port_idle),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NV         = 4;

    // vector table: opcode, phy, reg, data field, PHY reply, divider select
    localparam logic [1:0]  V_OP  [NV] = '{2'b10, 2'b01, 2'b10, 2'b01};
    localparam logic [4:0]  V_PHY [NV] = '{5'd1, 5'd31, 5'd0, 5'd17};
    localparam logic [4:0]  V_REG [NV] = '{5'd2, 5'd0, 5'd31, 5'd9};
    localparam logic [15:0] V_DAT [NV] = '{16'h0000, 16'hA55A, 16'hFFFF, 16'h1234};
    localparam logic [15:0] V_RSP [NV] = '{16'hBEEF, 16'h0000, 16'h8001, 16'hFFFF};
    localparam logic        V_SEL [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mgmt_en = 1'b1;
    logic        div_sel = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        port_idle;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int t_r0 = 0;
    int t_r1 = 0;
    logic [63:0] cap_o;
    logic [63:0] cap_oe;
    logic [15:0] phy_reply = '0;

    mdio_mgmt_ctrl dut_i (
        .clk(clk), .rst(rst), .mgmt_en(mgmt_en), .div_sel(div_sel),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .port_idle(port_idle), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog act %0d exp <%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // line monitor: record what is on the wire at each MDC rise
    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_o[63 - rise_cnt]  = mdio_o;
            cap_oe[63 - rise_cnt] = mdio_oe;
        end
        if (rise_cnt == 0) t_r0 = cyc;
        if (rise_cnt == 1) t_r1 = cyc;
        rise_cnt = rise_cnt + 1;
    end

    // PHY model: present reply bits after MDC falls in the data field
    always @(negedge mdc) begin
        fall_cnt = fall_cnt + 1;
        if (fall_cnt >= 48 && fall_cnt <= 63)
            mdio_i = phy_reply[63 - fall_cnt];
        else
            mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {2'b01, op, phy, rg, 2'b10, d};
    endfunction

    task automatic arm(input logic [15:0] reply);
        rise_cnt  = 0;
        fall_cnt  = 0;
        cap_o     = '0;
        cap_oe    = '0;
        phy_reply = reply;
        mdio_i    = 1'b1;
    endtask

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wr    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    task automatic wait_idle(output int busy_cycles);
        busy_cycles = 0;
        while (!port_idle) begin
            busy_cycles = busy_cycles + 1;
            @(negedge clk);
        end
    endtask

    initial begin
        int bc;
        logic [31:0] w;
        logic [31:0] exp_reg;
        int lim;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 idle", 64'(port_idle), 64'd1);
        chk("R1 mdc", 64'(mdc), 64'd0);
        chk("R1 oe", 64'(mdio_oe), 64'd0);
        chk("R1 reg", 64'(cmd_rdata), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            w       = mk(V_OP[i], V_PHY[i], V_REG[i], V_DAT[i]);
            lim     = V_SEL[i] ? 64 : 48;
            div_sel = V_SEL[i];
            arm(V_RSP[i]);
            write_cmd(w);
            chk("R2 busy after write", 64'(port_idle), 64'd0);
            wait_idle(bc);
            chk("R2 frame length", 64'(bc), 64'(64 * lim));
            chk("R2 mdc rises", 64'(rise_cnt), 64'd64);
            chk("R4 mdc period", 64'(t_r1 - t_r0), 64'(lim));
            chk("R3 wire stream", cap_o, {32'hFFFF_FFFF, w});
            if (V_OP[i] == 2'b10) begin
                chk("R6 read oe", cap_oe, 64'hFFFF_FFFF_FFFE_0000);
                exp_reg = {w[31:16], V_RSP[i]};
                chk("R5 R7 read data", 64'(cmd_rdata), 64'(exp_reg));
            end else begin
                chk("R6 write oe", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
                chk("R7 write reg kept", 64'(cmd_rdata), 64'(w));
            end
            chk("R1 idle mdc low", 64'(mdc), 64'd0);
        end

        // R4 half-period: mdc low for the first half after launch
        div_sel = 1'b0;
        arm(16'h0);
        w = mk(2'b01, 5'd3, 5'd4, 16'h0F0F);
        write_cmd(w);
        repeat (22) @(negedge clk);
        chk("R4 low half", 64'(mdc), 64'd0);
        repeat (2) @(negedge clk);
        chk("R4 high half", 64'(mdc), 64'd1);

        // R8 write while busy ignored
        repeat (300) @(negedge clk);
        write_cmd(32'h6ABC_DEF0);
        chk("R8 reg during busy", 64'(cmd_rdata), 64'(w));
        wait_idle(bc);
        chk("R8 stream unchanged", cap_o, {32'hFFFF_FFFF, w});
        chk("R8 reg after", 64'(cmd_rdata), 64'(w));

        // R9 disabled port ignores writes
        mgmt_en = 1'b0;
        write_cmd(mk(2'b10, 5'd5, 5'd6, 16'h0));
        chk("R9 idle when disabled", 64'(port_idle), 64'd1);
        chk("R9 reg kept when disabled", 64'(cmd_rdata), 64'(w));
        chk("R9 mdc low", 64'(mdc), 64'd0);

        // R9 abort mid-frame
        mgmt_en = 1'b1;
        arm(16'h1111);
        w = mk(2'b10, 5'd7, 5'd8, 16'h0);
        write_cmd(w);
        repeat (500) @(negedge clk);
        chk("R9 busy before abort", 64'(port_idle), 64'd0);
        mgmt_en = 1'b0;
        @(negedge clk);
        chk("R9 idle after abort", 64'(port_idle), 64'd1);
        chk("R9 oe after abort", 64'(mdio_oe), 64'd0);
        chk("R9 mdc after abort", 64'(mdc), 64'd0);
        mgmt_en = 1'b1;

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule